// File: doc/BRIEF.md
# Tacho Speed Trip Detector

This block watches a spindle tacho pulse train and tells software when the spindle speed passes a programmed point. It synchronises the tacho input to the system clock and counts its rising edges over a fixed window of system clocks. Each window's count is the speed sample. The block compares each new sample, together with the one before it, against a trip point held in a register. When the speed moves across that point in the selected direction, a sticky status flag is set. An interrupt line is asserted while that flag and an enable bit are both set.

Software programs the trip point and picks the direction: rising above the point during spin-up, or falling below it during spin-down. It then waits for the interrupt and clears the flag by writing a one to it. A speed that stays beyond the trip point sets the flag only once. No event is raised until one complete window after reset has been measured.

Top module: `tacho_trip_det`

## Requirements
- R1: After reset the trip point, control and status registers all read 0 and irq_o is 0.
- R2: Address 0 reads and writes the trip point (CNT_W bits). Address 1 holds the control bits: bit 0 is the interrupt enable and bit 1 is the direction (1 = above, 0 = below). Unused control bits read 0.
- R3: The speed sample is the number of synchronised rising tacho edges in each window of WIN_CYCLES clocks, saturating at the count maximum. A new sample is produced once per window.
- R4: In above mode, status bit 3 (address 2) is set when the previous sample is not above the trip point and the new sample is above it.
- R5: In below mode, status bit 3 is set when the previous sample is not below the trip point and the new sample is below it.
- R6: A sample equal to the trip point counts as neither above nor below it.
- R7: A speed that stays beyond the trip point does not set the flag again. A crossing in the direction that is not selected has no effect.
- R8: Status bit 3 is sticky. Writing 1 to bit 3 of address 2 clears it. Writing 0 to bit 3 leaves it unchanged, and the other status bits always read 0.
- R9: irq_o is high exactly while status bit 3 and the enable bit are both set. The status flag is set whether or not the interrupt is enabled.
- R10: The first sample after reset only loads the comparison history and can never set the flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tacho_i | input | 1 | Raw tacho pulse, asynchronous |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 2 | Register address |
| reg_wdata_i | input | 8 | Register write data |
| reg_rdata_o | output | 8 | Register read data for reg_addr_i, combinational |
| irq_o | output | 1 | Speed trip interrupt |

## Verification
The bench drives tacho rates whose period divides the window length, so every settled sample is exact. It places samples exactly on the trip point. A design that treats equality as a crossing would raise a spurious flag there, and one that misses the strict comparison would stay silent on the next step. It holds a fast speed across many windows and reverses direction in each mode, which catches a level-triggered compare or an ignored direction bit. It writes zero and other bits to the status register, toggles the enable while a flag is pending, and resets the block while the tacho is already fast. A design without a history-valid guard would then fire on its first window.

// File: rtl/tacho_pkg.sv
package tacho_pkg;
  localparam int unsigned DATA_W = 8;
  localparam int unsigned ADDR_W = 2;

  localparam logic [ADDR_W-1:0] ADDR_TRIP = 2'd0;
  localparam logic [ADDR_W-1:0] ADDR_CTRL = 2'd1;
  localparam logic [ADDR_W-1:0] ADDR_STS  = 2'd2;

  localparam int unsigned CTRL_EN_BIT  = 0;
  localparam int unsigned CTRL_DIR_BIT = 1;
  localparam int unsigned STS_TRIP_BIT = 3;

  typedef enum logic {
    DIR_BELOW = 1'b0,
    DIR_ABOVE = 1'b1
  } trip_dir_e;
endpackage

// File: rtl/tacho_edge_sync.sv
module tacho_edge_sync #(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic tacho_i,
  output logic rise_o
);
  localparam int unsigned CHAIN_W = SYNC_STAGES + 1;

  logic [CHAIN_W-1:0] chain_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) chain_q <= '0;
    else         chain_q <= {chain_q[CHAIN_W-2:0], tacho_i};
  end

  // top two taps: synchronised level and its delayed copy
  assign rise_o = chain_q[CHAIN_W-2] & ~chain_q[CHAIN_W-1];
endmodule

// File: rtl/tacho_win_count.sv
module tacho_win_count #(
  parameter int unsigned WIN_CYCLES = 64,
  parameter int unsigned CNT_W      = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             rise_i,
  output logic [CNT_W-1:0] meas_o,
  output logic             meas_vld_o
);
  localparam int unsigned TMR_W   = (WIN_CYCLES > 1) ? $clog2(WIN_CYCLES) : 1;
  localparam logic [TMR_W-1:0] TMR_LAST = TMR_W'(WIN_CYCLES - 1);
  localparam logic [CNT_W-1:0] CNT_MAX  = '1;

  logic [TMR_W-1:0] tmr_q;
  logic [CNT_W-1:0] cnt_q, cnt_inc;
  logic             win_end;

  assign win_end = (tmr_q == TMR_LAST);
  assign cnt_inc = (rise_i && cnt_q != CNT_MAX) ? cnt_q + 1'b1 : cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tmr_q      <= '0;
      cnt_q      <= '0;
      meas_o     <= '0;
      meas_vld_o <= 1'b0;
    end else if (win_end) begin
      tmr_q      <= '0;
      cnt_q      <= '0;
      meas_o     <= cnt_inc;
      meas_vld_o <= 1'b1;
    end else begin
      tmr_q      <= tmr_q + 1'b1;
      cnt_q      <= cnt_inc;
      meas_vld_o <= 1'b0;
    end
  end
endmodule

// File: rtl/tacho_trip_cmp.sv
module tacho_trip_cmp
  import tacho_pkg::*;
#(
  parameter int unsigned CNT_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [CNT_W-1:0] meas_i,
  input  logic             meas_vld_i,
  input  logic [CNT_W-1:0] trip_i,
  input  trip_dir_e        dir_i,
  output logic             trip_o
);
  logic [CNT_W-1:0] prev_q;
  logic             hist_vld_q;
  logic             cross_up, cross_dn, hit;

  assign cross_up = (prev_q <= trip_i) && (meas_i > trip_i);
  assign cross_dn = (prev_q >= trip_i) && (meas_i < trip_i);
  assign hit      = (dir_i == DIR_ABOVE) ? cross_up : cross_dn;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      prev_q     <= '0;
      hist_vld_q <= 1'b0;
      trip_o     <= 1'b0;
    end else if (meas_vld_i) begin
      prev_q     <= meas_i;
      hist_vld_q <= 1'b1;
      trip_o     <= hist_vld_q && hit;
    end else begin
      trip_o     <= 1'b0;
    end
  end
endmodule

// File: rtl/tacho_regs.sv
module tacho_regs
  import tacho_pkg::*;
#(
  parameter int unsigned CNT_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  input  logic              trip_evt_i,
  output logic [CNT_W-1:0]  trip_o,
  output trip_dir_e         dir_o,
  output logic              en_o,
  output logic              sts_o
);
  logic wr_trip, wr_ctrl, clr_sts;
  logic unused_wdata;

  assign wr_trip = we_i && (addr_i == ADDR_TRIP);
  assign wr_ctrl = we_i && (addr_i == ADDR_CTRL);
  assign clr_sts = we_i && (addr_i == ADDR_STS) && wdata_i[STS_TRIP_BIT];
  assign unused_wdata = ^wdata_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      trip_o <= '0;
      en_o   <= 1'b0;
      dir_o  <= DIR_BELOW;
      sts_o  <= 1'b0;
    end else begin
      if (wr_trip) trip_o <= wdata_i[CNT_W-1:0];
      if (wr_ctrl) begin
        en_o  <= wdata_i[CTRL_EN_BIT];
        dir_o <= trip_dir_e'(wdata_i[CTRL_DIR_BIT]);
      end
      // a new event wins over a simultaneous clear
      if (trip_evt_i)   sts_o <= 1'b1;
      else if (clr_sts) sts_o <= 1'b0;
    end
  end

  always_comb begin
    rdata_o = '0;
    unique case (addr_i)
      ADDR_TRIP: rdata_o[CNT_W-1:0] = trip_o;
      ADDR_CTRL: begin
        rdata_o[CTRL_EN_BIT]  = en_o;
        rdata_o[CTRL_DIR_BIT] = dir_o;
      end
      ADDR_STS:  rdata_o[STS_TRIP_BIT] = sts_o;
      default:   rdata_o = '0;
    endcase
  end
endmodule

// File: rtl/tacho_trip_det.sv
module tacho_trip_det
  import tacho_pkg::*;
#(
  parameter int unsigned WIN_CYCLES  = 64,
  parameter int unsigned CNT_W       = 8,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tacho_i,
  input  logic              reg_we_i,
  input  logic [ADDR_W-1:0] reg_addr_i,
  input  logic [DATA_W-1:0] reg_wdata_i,
  output logic [DATA_W-1:0] reg_rdata_o,
  output logic              irq_o
);
  logic             rise;
  logic [CNT_W-1:0] meas_cnt;
  logic             meas_vld;
  logic [CNT_W-1:0] trip_pt;
  trip_dir_e        dir_sel;
  logic             irq_en;
  logic             trip_pulse;
  logic             sts;

  tacho_edge_sync #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .tacho_i(tacho_i),
    .rise_o (rise)
  );

  tacho_win_count #(.WIN_CYCLES(WIN_CYCLES), .CNT_W(CNT_W)) u_win (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .rise_i    (rise),
    .meas_o    (meas_cnt),
    .meas_vld_o(meas_vld)
  );

  tacho_trip_cmp #(.CNT_W(CNT_W)) u_cmp (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .meas_i    (meas_cnt),
    .meas_vld_i(meas_vld),
    .trip_i    (trip_pt),
    .dir_i     (dir_sel),
    .trip_o    (trip_pulse)
  );

  tacho_regs #(.CNT_W(CNT_W)) u_regs (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .we_i      (reg_we_i),
    .addr_i    (reg_addr_i),
    .wdata_i   (reg_wdata_i),
    .rdata_o   (reg_rdata_o),
    .trip_evt_i(trip_pulse),
    .trip_o    (trip_pt),
    .dir_o     (dir_sel),
    .en_o      (irq_en),
    .sts_o     (sts)
  );

  assign irq_o = sts & irq_en;
endmodule

// File: rtl/tacho_trip_det_chk.sv
module tacho_trip_det_chk
  import tacho_pkg::*;
#(
  parameter int unsigned CNT_W = 8
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              reg_we_i,
  input logic [ADDR_W-1:0] reg_addr_i,
  input logic [DATA_W-1:0] reg_wdata_i,
  input logic              irq_o,
  input logic [CNT_W-1:0]  meas_cnt,
  input logic              meas_vld,
  input logic [CNT_W-1:0]  trip_pt,
  input trip_dir_e         dir_sel,
  input logic              trip_pulse,
  input logic              sts
);
  logic [1:0] vld_seen_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                         vld_seen_q <= '0;
    else if (meas_vld && vld_seen_q != 2) vld_seen_q <= vld_seen_q + 1'b1;
  end

  // R3
  win_strobe_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    meas_vld |=> !meas_vld);

  // R10
  no_early_trip_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    trip_pulse |-> vld_seen_q == 2'd2);

  // R4 R5 R6
  trip_dir_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    trip_pulse |-> $past((dir_sel == DIR_ABOVE) ? (meas_cnt > trip_pt)
                                                : (meas_cnt < trip_pt)));

  // R8
  sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sts && !(reg_we_i && reg_addr_i == ADDR_STS && reg_wdata_i[STS_TRIP_BIT]))
      |=> sts);

  // R8
  trip_sets_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    trip_pulse |=> sts);

  // R9
  irq_needs_sts_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> sts);
endmodule

bind tacho_trip_det tacho_trip_det_chk #(.CNT_W(CNT_W)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .reg_we_i   (reg_we_i),
  .reg_addr_i (reg_addr_i),
  .reg_wdata_i(reg_wdata_i),
  .irq_o      (irq_o),
  .meas_cnt   (meas_cnt),
  .meas_vld   (meas_vld),
  .trip_pt    (trip_pt),
  .dir_sel    (dir_sel),
  .trip_pulse (trip_pulse),
  .sts        (sts)
);

// File: tb/tacho_trip_det_bench.sv
`timescale 1ns/1ps
module tacho_trip_det_bench;
  localparam int WIN = 64;
  localparam logic [1:0] A_TRIP = 2'd0, A_CTRL = 2'd1, A_STS = 2'd2;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tacho = 1'b0;
  logic       we = 1'b0;
  logic [1:0] addr = A_STS;
  logic [7:0] wdata = '0;
  logic [7:0] rdata;
  logic       irq;

  int n_chk = 0, n_bad = 0;
  int period = 0;
  bit done = 1'b0;

  logic [7:0] q_data[$];
  logic       q_irq[$];
  string      q_tag[$];

  always #4 clk = ~clk;

  tacho_trip_det #(.WIN_CYCLES(WIN)) u_tacho_trip_det (
    .clk_i(clk), .rst_ni(rst_n), .tacho_i(tacho),
    .reg_we_i(we), .reg_addr_i(addr), .reg_wdata_i(wdata),
    .reg_rdata_o(rdata), .irq_o(irq)
  );

  // tacho generator: period in clocks, 0 = stopped
  initial begin
    forever begin
      if (period == 0) begin
        @(negedge clk); tacho = 1'b0;
      end else begin
        repeat (period / 2) @(negedge clk);
        tacho = ~tacho;
      end
    end
  end

  // monitor: pops one expected item per cycle, samples after the edge
  always @(posedge clk) begin
    #1;
    if (q_data.size() > 0) begin
      logic [7:0] ed; logic ei; string t;
      ed = q_data.pop_front(); ei = q_irq.pop_front(); t = q_tag.pop_front();
      n_chk++;
      if (rdata !== ed || irq !== ei) begin
        n_bad++;
        $display("FAIL %s: rdata=%h irq=%b expected rdata=%h irq=%b", t, rdata, irq, ed, ei);
      end
    end
  end

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk); we = 1'b1; addr = a; wdata = d;
    @(negedge clk); we = 1'b0; addr = A_STS; wdata = '0;
  endtask

  task automatic expect_rd(input logic [1:0] a, input logic [7:0] d, input logic i, input string t);
    @(negedge clk); addr = a;
    q_data.push_back(d); q_irq.push_back(i); q_tag.push_back(t);
    @(negedge clk); addr = A_STS;
  endtask

  task automatic run_speed(input int p, input int nwin);
    period = p;
    repeat (nwin * WIN) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1
    expect_rd(A_STS, 8'h00, 1'b0, "R1 status after reset");
    expect_rd(A_TRIP, 8'h00, 1'b0, "R1 trip after reset");
    expect_rd(A_CTRL, 8'h00, 1'b0, "R1 ctrl after reset");
    // R2
    wr(A_CTRL, 8'hFF);
    expect_rd(A_CTRL, 8'h03, 1'b0, "R2 ctrl unused bits");
    wr(A_TRIP, 8'd6);
    wr(A_CTRL, 8'h03);
    expect_rd(A_TRIP, 8'd6, 1'b0, "R2 trip readback");
    expect_rd(A_CTRL, 8'h03, 1'b0, "R2 ctrl readback");
    // R3 R7: 4 edges per window, below trip in above mode
    run_speed(16, 4);
    expect_rd(A_STS, 8'h00, 1'b0, "R7 slow below trip, above mode");
    // R4: 16 per window
    run_speed(4, 4);
    expect_rd(A_STS, 8'h08, 1'b1, "R4 rise above trip");
    // R8 clear
    wr(A_STS, 8'h08);
    expect_rd(A_STS, 8'h00, 1'b0, "R8 w1c clears");
    run_speed(4, 4);
    expect_rd(A_STS, 8'h00, 1'b0, "R7 no refire while above");
    run_speed(16, 4);
    expect_rd(A_STS, 8'h00, 1'b0, "R7 fall ignored in above mode");
    // R6: exactly on trip
    wr(A_TRIP, 8'd8);
    run_speed(8, 4);
    expect_rd(A_STS, 8'h00, 1'b0, "R6 equal is not above");
    run_speed(4, 4);
    expect_rd(A_STS, 8'h08, 1'b1, "R4 R6 rise from equal");
    wr(A_STS, 8'h08);
    // below mode, enabled
    wr(A_CTRL, 8'h01);
    run_speed(8, 4);
    expect_rd(A_STS, 8'h00, 1'b0, "R6 equal is not below");
    run_speed(16, 4);
    expect_rd(A_STS, 8'h08, 1'b1, "R5 fall below trip");
    wr(A_STS, 8'h00);
    expect_rd(A_STS, 8'h08, 1'b1, "R8 write zero keeps flag");
    wr(A_STS, 8'hF7);
    expect_rd(A_STS, 8'h08, 1'b1, "R8 other bits keep flag");
    wr(A_STS, 8'h08);
    expect_rd(A_STS, 8'h00, 1'b0, "R8 clear after hold");
    // R9: disabled, below mode
    wr(A_CTRL, 8'h00);
    run_speed(4, 4);
    expect_rd(A_STS, 8'h00, 1'b0, "R7 rise ignored in below mode");
    run_speed(32, 4);
    expect_rd(A_STS, 8'h08, 1'b0, "R9 flag set with irq disabled");
    wr(A_CTRL, 8'h01);
    expect_rd(A_STS, 8'h08, 1'b1, "R9 enable raises irq");
    wr(A_STS, 8'h08);
    expect_rd(A_STS, 8'h00, 1'b0, "R9 clear drops irq");
    run_speed(0, 4);
    expect_rd(A_STS, 8'h00, 1'b0, "R7 stop while already below");
    // R10: reset while spinning fast
    period = 4;
    repeat (100) @(negedge clk);
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    expect_rd(A_STS, 8'h00, 1'b0, "R1 status after mid-run reset");
    wr(A_TRIP, 8'd6);
    wr(A_CTRL, 8'h03);
    run_speed(4, 4);
    expect_rd(A_STS, 8'h00, 1'b0, "R10 no event from first window");
    repeat (4) @(negedge clk);
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end
endmodule